// File: doc/BRIEF.md
# Doorbell Command Mailbox Dispatcher

This block is the command front end of a memory-expander device. The host fills a 32-bit command register with a command set, a command code and an input payload length. It then rings a doorbell. The engine forms a 16-bit opcode from the register and searches a fixed table of supported commands. It checks the declared input length against that command's entry and, when both checks pass, selects one of the built-in stub responders. The stub reports a return code and an output length.

Some responders zero-fill their output area in an external payload RAM through a byte-wide write stream. The stream uses valid/ready. Once raised, valid stays high with a stable address and data until ready is seen high at a clock edge. The RAM may hold ready low for any number of cycles, and the engine waits without losing a byte.

On completion the engine writes three things on one clock edge. The return code goes into the status register. The set and command fields are cleared and the output length replaces the length field. The doorbell is dropped on that same edge, so the host never sees the doorbell low before the results are in place. Capacity figures that real handlers would report are counted in units of 256 MiB. The stubs here report none.

Top module: `mbx_dispatch`

## Requirements
- R1: The command register is laid out as bits [7:0] command, [15:8] command set and [31:16] input length. The opcode is set<<8 | command. A doorbell write of 1 starts a command only while the engine is idle, and `doorbell_o` and `busy_o` go high on the next clock. Command-register and doorbell writes made while busy are ignored. A doorbell write of 0 while idle does nothing. A command-register write while idle is stored and visible on `cmd_reg_o`.
- R2: An opcode not in the table completes with return code 0x03. The length field keeps the input length.
- R3: The supported table is given as opcode: input length → output length, with z marking zero-fill:
  - 0x0100: 1 → 0x20 z
  - 0x0101: any → 0
  - 0x0102: 0 → 4 z
  - 0x0103: 4 → 0
  - 0x0200: 0 → 0x50
  - 0x0300: 0 → 8 z
  - 0x0301: 8 → 0
  - 0x0400: 0 → 0x1c z
  - 0x0401: 0x18 → 0x18 z
  - 0x4000: 0 → 0x43
  - 0x4100: 0 → 0x20 z
  - 0x4102: 8 → 0x10 z
  - 0x4103: any → 0

  "Any" is the all-ones marker 0xFFFF, which accepts every length. For every other entry, a length that differs from the entry completes with return code 0x16, and the length field keeps the input length. The length check comes before the handler runs.
- R4: For a command that passes the checks, `hsel_valid_o` is high for exactly one cycle (the second cycle after acceptance). `hsel_idx_o` then carries the entry's position (0 to 12) in the ascending opcode order of R3.
- R5: A handler output length greater than PAY_BYTES (default 64) completes with return code 0x04 and output length 0, and no payload bytes are written.
- R6: A successful command completes with return code 0x00 and the handler's output length in [31:16]. Every completion clears bits [15:0] of the command register.
- R7: A zero-fill handler with output length N writes data 0 to payload addresses 0 to N-1 in ascending order, one byte per accepted beat. While ready is low, valid stays high with the address held.
- R8: `busy_o` always equals `doorbell_o`. The status and command registers take their final values on the same edge that clears the doorbell.
- R9: After reset, the doorbell, busy, command register, status, `hsel_valid_o` and `pay_valid_o` are all 0.
- R10: Counted in cycles with the doorbell high after the accepting edge:
  - a length or opcode error completes in 2 cycles;
  - a handler without fill, or an oversize result, completes in 3 cycles;
  - a fill of N bytes with ready held high completes in 3+N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_we | input | 1 | Command register write strobe |
| host_cmd_wdata | input | 32 | Command register write value |
| host_db_we | input | 1 | Doorbell write strobe |
| host_db_wdata | input | 1 | Doorbell write value |
| cmd_reg_o | output | 32 | Command register contents |
| status_o | output | 8 | Return code of the last completed command |
| doorbell_o | output | 1 | Doorbell bit |
| busy_o | output | 1 | Engine busy |
| hsel_valid_o | output | 1 | Handler select strobe |
| hsel_idx_o | output | 4 | Selected table index |
| pay_valid_o | output | 1 | Payload write valid |
| pay_ready_i | input | 1 | Payload write ready |
| pay_addr_o | output | 6 | Payload byte address |
| pay_data_o | output | 8 | Payload byte data |

## Verification
The assertions assume the following about the block's inputs:
- the table holds distinct opcodes, so at most one entry can match;
- host strobes are known from reset onward;
- the payload RAM may hold ready low indefinitely, but the stream properties only look one cycle ahead.

The stimulus keeps within these assumptions. It drives every host write as a single-cycle pulse at the falling edge. It toggles ready in a fixed pattern during one fill and holds it high elsewhere. It also issues writes during busy periods only as whole-cycle pulses, so the ignore rules of R1 are exercised without undefined values.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int CMD_W    = 32;
  localparam int LEN_W    = 16;
  localparam int OPC_W    = 16;
  localparam int RC_W     = 8;
  localparam int NUM_CMDS = 13;
  localparam int IDX_W    = $clog2(NUM_CMDS);

  localparam logic [LEN_W-1:0] LEN_ANY = '1;

  localparam logic [RC_W-1:0] RC_OK       = 8'h00;
  localparam logic [RC_W-1:0] RC_UNSUP    = 8'h03;
  localparam logic [RC_W-1:0] RC_INTERNAL = 8'h04;
  localparam logic [RC_W-1:0] RC_BADLEN   = 8'h16;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic [LEN_W-1:0] in_len;
    logic [LEN_W-1:0] out_len;
    logic             zero_fill;
  } cmd_entry_t;

  // Entries kept in ascending opcode order; the position is the handler index.
  function automatic cmd_entry_t cmd_entry(input int unsigned idx);
    cmd_entry_t e;
    e = '0;
    case (idx)
      0:  e = '{16'h0100, 16'd1,   16'h0020, 1'b1};
      1:  e = '{16'h0101, LEN_ANY, 16'h0000, 1'b0};
      2:  e = '{16'h0102, 16'd0,   16'h0004, 1'b1};
      3:  e = '{16'h0103, 16'd4,   16'h0000, 1'b0};
      4:  e = '{16'h0200, 16'd0,   16'h0050, 1'b0};
      5:  e = '{16'h0300, 16'd0,   16'h0008, 1'b1};
      6:  e = '{16'h0301, 16'd8,   16'h0000, 1'b0};
      7:  e = '{16'h0400, 16'd0,   16'h001c, 1'b1};
      8:  e = '{16'h0401, 16'h18,  16'h0018, 1'b1};
      9:  e = '{16'h4000, 16'd0,   16'h0043, 1'b0};
      10: e = '{16'h4100, 16'd0,   16'h0020, 1'b1};
      11: e = '{16'h4102, 16'd8,   16'h0010, 1'b1};
      12: e = '{16'h4103, LEN_ANY, 16'h0000, 1'b0};
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/mbx_cmd_table.sv
`timescale 1ns/1ps
module mbx_cmd_table
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [LEN_W-1:0] in_len_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             len_ok_o
);
  logic [NUM_CMDS-1:0] match;
  logic [LEN_W-1:0]    ent_len [NUM_CMDS];
  logic [LEN_W-1:0]    sel_len;

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_ent
    assign match[i]   = (cmd_entry(i).opcode == opcode_i);
    assign ent_len[i] = cmd_entry(i).in_len;
  end

  always_comb begin
    idx_o   = '0;
    sel_len = '0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (match[i]) begin
        idx_o   = IDX_W'(i);
        sel_len = ent_len[i];
      end
    end
  end

  assign hit_o    = |match;
  assign len_ok_o = (sel_len == LEN_ANY) || (sel_len == in_len_i);

  // R3: the table never matches two entries for one opcode
  assert_unique_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/mbx_stub_handlers.sv
`timescale 1ns/1ps
module mbx_stub_handlers
  import mbx_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [RC_W-1:0]  rc_o,
  output logic [LEN_W-1:0] out_len_o,
  output logic             zero_fill_o
);
  logic [LEN_W-1:0]    rsp_len [NUM_CMDS];
  logic [NUM_CMDS-1:0] rsp_zero;

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_rsp
    assign rsp_len[i]  = cmd_entry(i).out_len;
    assign rsp_zero[i] = cmd_entry(i).zero_fill;
  end

  always_comb begin
    out_len_o   = '0;
    zero_fill_o = 1'b0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (idx_i == IDX_W'(i)) begin
        out_len_o   = rsp_len[i];
        zero_fill_o = rsp_zero[i];
      end
    end
  end

  assign rc_o = RC_OK;
endmodule

// File: rtl/mbx_zero_fill.sv
`timescale 1ns/1ps
module mbx_zero_fill
  import mbx_pkg::*;
#(
  parameter int PAY_BYTES = 64,
  localparam int PAY_AW = $clog2(PAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  count_i,
  output logic              pay_valid_o,
  input  logic              pay_ready_i,
  output logic [PAY_AW-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o,
  output logic              done_o
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(PAY_BYTES);

  logic             active_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] total_q;
  logic             last;

  assign last   = (cnt_q == total_q - 1'b1);
  assign done_o = active_q && pay_ready_i && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      total_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      total_q  <= count_i;
    end else if (active_q && pay_ready_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) active_q <= 1'b0;
    end
  end

  assign pay_valid_o = active_q;
  assign pay_addr_o  = cnt_q[PAY_AW-1:0];
  assign pay_data_o  = 8'h00;

  // R7: a stalled beat keeps valid and address until accepted
  assert_pay_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid_o && !pay_ready_i) |=> (pay_valid_o && $stable(pay_addr_o)));
  // R5: no beat addresses past the payload buffer
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid_o |-> (cnt_q < LIMIT));
endmodule

// File: rtl/mbx_dispatch.sv
`timescale 1ns/1ps
module mbx_dispatch
  import mbx_pkg::*;
#(
  parameter int PAY_BYTES = 64,
  localparam int PAY_AW = $clog2(PAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd_we,
  input  logic [31:0]       host_cmd_wdata,
  input  logic              host_db_we,
  input  logic              host_db_wdata,
  output logic [31:0]       cmd_reg_o,
  output logic [7:0]        status_o,
  output logic              doorbell_o,
  output logic              busy_o,
  output logic              hsel_valid_o,
  output logic [3:0]        hsel_idx_o,
  output logic              pay_valid_o,
  input  logic              pay_ready_i,
  output logic [PAY_AW-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o
);
  localparam logic [LEN_W-1:0] PAY_LIMIT = LEN_W'(PAY_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_LOOKUP, S_HANDLE, S_FILL, S_DONE} state_t;

  state_t            state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              db_q;
  logic [RC_W-1:0]   rc_q;
  logic [RC_W-1:0]   status_q;
  logic [LEN_W-1:0]  out_len_q;
  logic [IDX_W-1:0]  idx_q;

  logic              tbl_hit, tbl_len_ok;
  logic [IDX_W-1:0]  tbl_idx;
  logic [RC_W-1:0]   stub_rc;
  logic [LEN_W-1:0]  stub_len;
  logic              stub_zero;
  logic              oversize, fill_start, fill_done, busy;

  mbx_cmd_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode_i (cmd_q[15:0]),
    .in_len_i (cmd_q[31:16]),
    .hit_o    (tbl_hit),
    .idx_o    (tbl_idx),
    .len_ok_o (tbl_len_ok)
  );

  mbx_stub_handlers u_stubs (
    .idx_i       (idx_q),
    .rc_o        (stub_rc),
    .out_len_o   (stub_len),
    .zero_fill_o (stub_zero)
  );

  assign oversize   = stub_len > PAY_LIMIT;
  assign fill_start = (state_q == S_HANDLE) && !oversize && stub_zero && (stub_len != '0);

  mbx_zero_fill #(.PAY_BYTES(PAY_BYTES)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (fill_start),
    .count_i     (stub_len),
    .pay_valid_o (pay_valid_o),
    .pay_ready_i (pay_ready_i),
    .pay_addr_o  (pay_addr_o),
    .pay_data_o  (pay_data_o),
    .done_o      (fill_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cmd_q     <= '0;
      db_q      <= 1'b0;
      rc_q      <= RC_OK;
      status_q  <= RC_OK;
      out_len_q <= '0;
      idx_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (host_cmd_we) cmd_q <= host_cmd_wdata;
          if (host_db_we && host_db_wdata) begin
            db_q    <= 1'b1;
            state_q <= S_LOOKUP;
          end
        end
        S_LOOKUP: begin
          out_len_q <= cmd_q[31:16];
          if (!tbl_hit) begin
            rc_q    <= RC_UNSUP;
            state_q <= S_DONE;
          end else if (!tbl_len_ok) begin
            rc_q    <= RC_BADLEN;
            state_q <= S_DONE;
          end else begin
            idx_q   <= tbl_idx;
            state_q <= S_HANDLE;
          end
        end
        S_HANDLE: begin
          if (oversize) begin
            rc_q      <= RC_INTERNAL;
            out_len_q <= '0;
            state_q   <= S_DONE;
          end else begin
            rc_q      <= stub_rc;
            out_len_q <= stub_len;
            state_q   <= fill_start ? S_FILL : S_DONE;
          end
        end
        S_FILL: begin
          if (fill_done) state_q <= S_DONE;
        end
        S_DONE: begin
          cmd_q    <= {out_len_q, 16'h0000};
          status_q <= rc_q;
          db_q     <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign busy_o       = busy;
  assign doorbell_o   = db_q;
  assign cmd_reg_o    = cmd_q;
  assign status_o     = status_q;
  assign hsel_valid_o = (state_q == S_HANDLE);
  assign hsel_idx_o   = 4'(idx_q);

  // R8: busy and doorbell move together
  assert_busy_is_db_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy == db_q);
  // R1: command register frozen while a command is in flight
  assert_cmd_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q != S_DONE) |=> $stable(cmd_q));
  // R2: missing opcode leads to the unsupported code
  assert_unsupported_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOOKUP && !tbl_hit) |=> (state_q == S_DONE && rc_q == RC_UNSUP));
  // R3: wrong length leads to the length code
  assert_bad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOOKUP && tbl_hit && !tbl_len_ok) |=> (rc_q == RC_BADLEN));
  // R4: handler select is a single-cycle strobe
  assert_hsel_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hsel_valid_o |=> !hsel_valid_o);
  // R5: oversize handler result becomes internal error with zero length
  assert_oversize_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HANDLE && oversize) |=> (rc_q == RC_INTERNAL && out_len_q == '0 && !pay_valid_o));
  // R6: completion clears set/command and publishes status with the doorbell drop
  assert_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE) |=> (cmd_q[15:0] == 16'h0 && !db_q && status_q == $past(rc_q)));
endmodule

// File: tb/mbx_dispatch_tb_top.sv
`timescale 1ns/1ps
module mbx_dispatch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        db_we = 1'b0;
  logic        db_wd = 1'b0;
  logic        pay_ready = 1'b1;
  logic [31:0] cmd_reg_o;
  logic [7:0]  status_o;
  logic        doorbell_o, busy_o, hsel_valid_o, pay_valid_o;
  logic [3:0]  hsel_idx_o;
  logic [5:0]  pay_addr_o;
  logic [7:0]  pay_data_o;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int rcnt = 0;

  always #4 clk = ~clk;

  mbx_dispatch dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_cmd_we(cmd_we), .host_cmd_wdata(cmd_wdata),
    .host_db_we(db_we), .host_db_wdata(db_wd),
    .cmd_reg_o(cmd_reg_o), .status_o(status_o),
    .doorbell_o(doorbell_o), .busy_o(busy_o),
    .hsel_valid_o(hsel_valid_o), .hsel_idx_o(hsel_idx_o),
    .pay_valid_o(pay_valid_o), .pay_ready_i(pay_ready),
    .pay_addr_o(pay_addr_o), .pay_data_o(pay_data_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference table from the requirement text (own form, not the RTL's)
  function automatic void ref_lookup(input logic [15:0] opc, output bit found,
                                     output int inl, output int outl, output bit zf, output int ix);
    found = 1; zf = 0; ix = 0; inl = 0; outl = 0;
    case (opc)
      16'h0100: begin ix = 0;  inl = 1;      outl = 32; zf = 1; end
      16'h0101: begin ix = 1;  inl = 65535;  outl = 0;          end
      16'h0102: begin ix = 2;  inl = 0;      outl = 4;  zf = 1; end
      16'h0103: begin ix = 3;  inl = 4;      outl = 0;          end
      16'h0200: begin ix = 4;  inl = 0;      outl = 80;         end
      16'h0300: begin ix = 5;  inl = 0;      outl = 8;  zf = 1; end
      16'h0301: begin ix = 6;  inl = 8;      outl = 0;          end
      16'h0400: begin ix = 7;  inl = 0;      outl = 28; zf = 1; end
      16'h0401: begin ix = 8;  inl = 24;     outl = 24; zf = 1; end
      16'h4000: begin ix = 9;  inl = 0;      outl = 67;         end
      16'h4100: begin ix = 10; inl = 0;      outl = 32; zf = 1; end
      16'h4102: begin ix = 11; inl = 8;      outl = 16; zf = 1; end
      16'h4103: begin ix = 12; inl = 65535;  outl = 0;          end
      default:  found = 0;
    endcase
  endfunction

  // Cycle-by-cycle behavioural model
  int          m_phase = 0;
  logic [31:0] m_cmd = '0;
  logic        m_db = 1'b0;
  logic [7:0]  m_status = '0;
  logic [7:0]  m_code = '0;
  int          m_len = 0;
  int          m_outl = 0;
  int          m_fidx = 0;
  int          m_idx = 0;

  always @(posedge clk) begin
    bit f; int inl; int outl; bit zf; int ix;
    if (!rst_n) begin
      m_phase = 0; m_cmd = '0; m_db = 0; m_status = '0; m_fidx = 0; m_idx = 0;
    end else begin
      case (m_phase)
        0: begin
          if (cmd_we) m_cmd = cmd_wdata;
          if (db_we && db_wd) begin m_db = 1; m_phase = 1; end
        end
        1: begin
          ref_lookup(m_cmd[15:0], f, inl, outl, zf, ix);
          if (!f) begin m_code = 8'h03; m_len = int'(m_cmd[31:16]); m_phase = 4; end
          else if (inl != 65535 && inl != int'(m_cmd[31:16])) begin
            m_code = 8'h16; m_len = int'(m_cmd[31:16]); m_phase = 4;
          end else begin
            m_idx = ix; m_outl = outl; m_phase = zf ? 2 : 5;
          end
        end
        2, 5: begin
          if (m_outl > 64) begin m_code = 8'h04; m_len = 0; m_phase = 4; end
          else begin
            m_code = 8'h00; m_len = m_outl;
            if (m_phase == 2 && m_outl != 0) begin m_phase = 3; m_fidx = 0; end
            else m_phase = 4;
          end
        end
        3: begin
          if (pay_ready) begin
            m_fidx++;
            if (m_fidx == m_outl) m_phase = 4;
          end
        end
        default: begin
          m_cmd = {m_len[15:0], 16'h0000}; m_status = m_code; m_db = 0; m_phase = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "doorbell", doorbell_o, m_db);
      chk("R8", "busy", busy_o, m_db);
      chk("R6", "cmd_reg", cmd_reg_o, m_cmd);
      chk("R6", "status", status_o, m_status);
      chk("R4", "hsel_valid", hsel_valid_o, (m_phase == 2 || m_phase == 5));
      if (m_phase == 2 || m_phase == 5) chk("R4", "hsel_idx", hsel_idx_o, m_idx);
      chk("R7", "pay_valid", pay_valid_o, (m_phase == 3));
      if (m_phase == 3) begin
        chk("R7", "pay_addr", pay_addr_o, m_fidx);
        chk("R7", "pay_data", pay_data_o, 0);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    rcnt++;
    pay_ready = (rdy_mode == 0) ? 1'b1 : ((rcnt % 3) != 0);
  end

  task automatic run(input logic [15:0] opc, input logic [15:0] len, input logic [7:0] exp_code,
                     input logic [15:0] exp_len, input int exp_cyc, input string tag, input bit poke);
    int cyc = 0;
    @(negedge clk);
    cmd_we = 1; cmd_wdata = {len, opc}; db_we = 1; db_wd = 1;
    @(negedge clk);
    cmd_we = 0; db_we = 0; db_wd = 0;
    if (poke) begin
      cmd_we = 1; cmd_wdata = 32'h0001_0100; db_we = 1; db_wd = 1;
    end
    while (doorbell_o === 1'b1 && cyc < 500) begin
      cyc++;
      @(negedge clk);
      cmd_we = 0; db_we = 0; db_wd = 0;
    end
    chk(tag, "return code", status_o, exp_code);
    chk(tag, "length field", cmd_reg_o[31:16], exp_len);
    chk("R6", "set/cmd cleared", cmd_reg_o[15:0], 0);
    if (exp_cyc >= 0) chk("R10", "latency", cyc, exp_cyc);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "reset doorbell", doorbell_o, 0);
    chk("R9", "reset busy", busy_o, 0);
    chk("R9", "reset cmd", cmd_reg_o, 0);
    chk("R9", "reset status", status_o, 0);
    chk("R9", "reset pay_valid", pay_valid_o, 0);
    chk("R9", "reset hsel", hsel_valid_o, 0);

    run(16'h0103, 16'd4,    8'h00, 16'd0,    3,  "R6", 0);
    run(16'h0300, 16'd0,    8'h00, 16'd8,    11, "R7", 0);
    rdy_mode = 1;
    run(16'h0100, 16'd1,    8'h00, 16'h20,   -1, "R7", 0);
    rdy_mode = 0;
    run(16'h0500, 16'd7,    8'h03, 16'd7,    2,  "R2", 0);
    run(16'h0001, 16'd0,    8'h03, 16'd0,    2,  "R2", 0);
    run(16'h0403, 16'd0,    8'h03, 16'd0,    2,  "R2", 0);
    run(16'h0301, 16'd4,    8'h16, 16'd4,    2,  "R3", 0);
    run(16'h0301, 16'd8,    8'h00, 16'd0,    3,  "R3", 0);
    run(16'h4103, 16'h25,   8'h00, 16'd0,    3,  "R3", 0);
    run(16'h0101, 16'd0,    8'h00, 16'd0,    3,  "R3", 0);
    run(16'h4000, 16'd2,    8'h16, 16'd2,    2,  "R3", 0);
    run(16'h4000, 16'd0,    8'h04, 16'd0,    3,  "R5", 0);
    run(16'h0200, 16'd0,    8'h04, 16'd0,    3,  "R5", 0);
    run(16'h4102, 16'd8,    8'h00, 16'h10,   19, "R7", 0);
    run(16'h0401, 16'h18,   8'h00, 16'h18,   27, "R1", 1);
    run(16'h0102, 16'd0,    8'h00, 16'd4,    7,  "R7", 0);
    run(16'h0400, 16'd0,    8'h00, 16'h1c,   31, "R10", 0);
    run(16'h4100, 16'd0,    8'h00, 16'h20,   35, "R10", 0);

    // Idle doorbell write of 0 and a plain register write start nothing
    @(negedge clk);
    db_we = 1; db_wd = 0; cmd_we = 1; cmd_wdata = 32'h0004_0103;
    @(negedge clk);
    db_we = 0; cmd_we = 0;
    repeat (4) @(negedge clk);
    chk("R1", "doorbell after write of 0", doorbell_o, 0);
    chk("R1", "busy after write of 0", busy_o, 0);
    chk("R1", "idle cmd write stored", cmd_reg_o, 32'h0004_0103);
    run(16'h0103, 16'd4,    8'h00, 16'd0,    3,  "R6", 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    summary();
    $finish;
  end
endmodule